// File: doc/BRIEF.md
# Blind-Sampled Digital Clock and Data Recovery Phase Tracker

This block recovers the data phase and the data bits of a serial link from converter samples taken at two samples per unit interval (UI). The sampling clock is never locked to the incoming signal. Each core clock brings a parallel vector of signed samples. Wherever two neighbouring samples differ in sign, the block places the zero crossing inside the UI by linear interpolation, which gives a 3-bit crossing phase (eight steps per UI).

All crossing phases of a cycle are compared with a tracked average phase. Each difference is wrapped into half a UI either side, and the differences are summed. The sum drives two cascaded integrators whose gains are right shifts set from outside. The first integrator holds a saturating frequency term. The second holds the average phase, which wraps modulo one UI. The eye center lies half a UI from the average crossing phase. In each UI, the sample closer to the eye center is sliced into one recovered bit.

A two-state controller runs the loop. In IDLE the loop and the outputs hold. In TRACK every cycle updates the loop and delivers a recovered word. The transitions are: IDLE to TRACK when `en` is high at a clock edge, TRACK to IDLE when `en` is low at a clock edge, and both states stay as they are otherwise.

Top module: `cdr_phase_tracker`

## Requirements
- R1: While `rst_n` is low, `bits_out` is 0, `bits_valid` is 0 and `phase_avg` is 0. The state is IDLE and the stored previous sample is 0.
- R2: The state register takes the value of `en` at every clock edge (1 = TRACK, 0 = IDLE). After an edge taken in TRACK, `bits_valid` is 1. After an edge taken in IDLE, `bits_valid` is 0, and `bits_out` and `phase_avg` keep their values.
- R3: Sample n sits in `samples[5n+4:5n]` as two's complement. UI u owns sample 2u at phase code 0 and sample 2u+1 at phase code 4. The sample just before sample 0 is the last sample of the previous clock, which is stored on every edge, including edges taken in IDLE.
- R4: A crossing between a first sample x and a second sample y exists when exactly one of the two is negative. With S = |x|+|y|, its code is (base + floor((8|x|+S)/(2S))) mod 8. The base is 0 for the pair (2u, 2u+1) and 4 for the pair (2u-1, 2u).
- R5: If both pairs of a UI cross, the pair (2u, 2u+1) sets the code. A UI with no crossing adds zero error, so a cycle with no crossing leaves the error sum at zero.
- R6: The error of a crossing is (code·2^(PH_W-3) − phase_avg) mod 2^PH_W, read as a signed PH_W-bit number. This is the range [−0.5, 0.5) UI. The errors of the UIs of one cycle are summed into E.
- R7: On each TRACK edge the frequency term becomes the saturation of (freq + (E >>> `kf_shift`)) to the signed PH_W-bit range. `phase_avg` becomes (phase_avg + (E >>> `kp_shift`) + old freq) mod 2^PH_W. Both shifts are arithmetic.
- R8: The eye code is (phase_avg[PH_W-1:PH_W-3] + 4) mod 8. When it is 2, 3, 4 or 5, UI u slices sample 2u+1; otherwise it slices sample 2u. Bit u of the recovered word is 1 when the sliced sample is zero or positive. This uses `phase_avg` from before the update.
- R9: The word and the phase computed from the samples present at a TRACK edge appear on `bits_out` and `phase_avg` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Tracking enable, moves the controller between IDLE and TRACK |
| samples | input | NS*SW (80) | Parallel signed samples, two per UI, oldest at the low end |
| kp_shift | input | KP_W (3) | Right shift applied to the error sum on the phase path |
| kf_shift | input | KF_W (4) | Right shift applied to the error sum on the frequency path |
| bits_out | output | NS/2 (8) | Recovered word, bit u from UI u |
| bits_valid | output | 1 | High after each cycle processed in TRACK |
| phase_avg | output | PH_W (10) | Averaged crossing phase, top three bits in eighths of a UI |

## Verification
The bench targets several corner cases, and each has a visible failure. The first is a crossing that straddles the boundary between two cycles: a design that forgot the stored sample would miss it and its phase would drift apart from the model. The second is a sample of exactly zero next to a negative one; a design that treated zero as negative would find false crossings or slice wrong bits. The third is a steady drift of the data phase, which forces the average phase to wrap past one UI and pushes the frequency term into saturation; a design without a modulo wrap or without saturation would show a wrong `phase_avg` within a few cycles. The last is a stretch of constant data and of IDLE cycles: a design that updated on those cycles would move `phase_avg` or `bits_out` when both must hold.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    // eight phase steps per unit interval
    localparam int CODE_W = 3;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_t;

endpackage

// File: rtl/cdr_xing_interp.sv
module cdr_xing_interp #(
    parameter int SW = 5
) (
    input  logic signed [SW-1:0] x,
    input  logic signed [SW-1:0] y,
    input  logic [cdr_pkg::CODE_W-1:0] base,
    output logic hit,
    output logic [cdr_pkg::CODE_W-1:0] code
);
    localparam int AW = SW + 1;
    localparam int NW = SW + 5;

    logic signed [AW-1:0] xe, ye;
    logic [AW-1:0] ax, ay;
    logic [NW-1:0] span, num;
    logic [cdr_pkg::CODE_W-1:0] frac;

    always_comb begin
        xe = {x[SW-1], x};
        ye = {y[SW-1], y};
        ax = xe[AW-1] ? AW'(-xe) : AW'(xe);
        ay = ye[AW-1] ? AW'(-ye) : AW'(ye);
        span = NW'(ax) + NW'(ay);
        num = (NW'(ax) << 3) + span;
        frac = '0;
        // rounded 4*|x|/S, found by comparison instead of division
        for (int k = 1; k <= 4; k++) begin
            if (num >= NW'(2 * k) * span) begin
                frac = frac + 1'b1;
            end
        end
        hit = x[SW-1] ^ y[SW-1];
        code = base + frac;
    end

endmodule

// File: rtl/cdr_err_accum.sv
module cdr_err_accum #(
    parameter int NUI   = 8,
    parameter int PH_W  = 10,
    parameter int SUM_W = 13
) (
    input  logic [NUI-1:0] hit,
    input  logic [NUI*cdr_pkg::CODE_W-1:0] code,
    input  logic [PH_W-1:0] avg,
    output logic signed [SUM_W-1:0] err_sum
);
    localparam int CW = cdr_pkg::CODE_W;
    localparam int FR_W = PH_W - CW;

    logic [PH_W-1:0] diff;

    always_comb begin
        err_sum = '0;
        diff = '0;
        for (int u = 0; u < NUI; u++) begin
            // modulo subtraction: wraps into [-0.5, 0.5) UI
            diff = {code[u*CW +: CW], {FR_W{1'b0}}} - avg;
            if (hit[u]) begin
                err_sum = err_sum + SUM_W'($signed(diff));
            end
        end
    end

endmodule

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter #(
    parameter int PH_W  = 10,
    parameter int SUM_W = 13,
    parameter int KP_W  = 3,
    parameter int KF_W  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic signed [SUM_W-1:0] err_sum,
    input  logic [KP_W-1:0] kp_shift,
    input  logic [KF_W-1:0] kf_shift,
    output logic [PH_W-1:0] avg
);
    localparam int XW = SUM_W + 1;
    localparam logic signed [XW-1:0] FREQ_MAX = XW'(2 ** (PH_W - 1) - 1);
    localparam logic signed [XW-1:0] FREQ_MIN = -FREQ_MAX - XW'(1);

    logic signed [PH_W-1:0] freq_q, freq_d;
    logic signed [SUM_W-1:0] p_step, f_step;
    logic signed [XW-1:0] f_sum;
    logic [PH_W-1:0] avg_d;

    always_comb begin
        f_step = err_sum >>> kf_shift;
        p_step = err_sum >>> kp_shift;
        f_sum = XW'(freq_q) + XW'(f_step);
        if (f_sum > FREQ_MAX) begin
            freq_d = PH_W'(FREQ_MAX);
        end else if (f_sum < FREQ_MIN) begin
            freq_d = PH_W'(FREQ_MIN);
        end else begin
            freq_d = PH_W'(f_sum);
        end
        // phase integrator wraps modulo one UI
        avg_d = avg + PH_W'(p_step) + PH_W'(freq_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_q <= '0;
            avg <= '0;
        end else if (upd) begin
            freq_q <= freq_d;
            avg <= avg_d;
        end
    end

endmodule

// File: rtl/cdr_bit_slicer.sv
module cdr_bit_slicer #(
    parameter int NS = 16,
    parameter int SW = 5
) (
    input  logic [NS*SW-1:0] samples,
    input  logic [cdr_pkg::CODE_W-1:0] avg_code,
    output logic [NS/2-1:0] bits
);
    localparam int NUI = NS / 2;

    logic [cdr_pkg::CODE_W-1:0] eye;
    logic late;

    always_comb begin
        eye = avg_code + cdr_pkg::CODE_W'(4);
        // eye codes 2..5 sit closer to the half-UI sample
        late = eye[2] ^ eye[1];
        for (int u = 0; u < NUI; u++) begin
            if (late) begin
                bits[u] = ~samples[(2*u+1)*SW + SW - 1];
            end else begin
                bits[u] = ~samples[(2*u)*SW + SW - 1];
            end
        end
    end

endmodule

// File: rtl/cdr_phase_tracker.sv
module cdr_phase_tracker
    import cdr_pkg::*;
#(
    parameter int NS   = 16,
    parameter int SW   = 5,
    parameter int PH_W = 10,
    parameter int KP_W = 3,
    parameter int KF_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic [NS*SW-1:0] samples,
    input  logic [KP_W-1:0] kp_shift,
    input  logic [KF_W-1:0] kf_shift,
    output logic [NS/2-1:0] bits_out,
    output logic bits_valid,
    output logic [PH_W-1:0] phase_avg
);
    localparam int NUI = NS / 2;
    localparam int SUM_W = PH_W + $clog2(NUI);

    trk_state_t state_q, state_d;
    logic signed [SW-1:0] prev_q;
    logic [NUI-1:0] ui_hit;
    logic [NUI*CODE_W-1:0] ui_code;
    logic signed [SUM_W-1:0] err_sum;
    logic [NUI-1:0] slice_bits;
    logic upd;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en)  state_d = ST_TRACK;
            ST_TRACK: if (!en) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign upd = (state_q == ST_TRACK);

    for (genvar u = 0; u < NUI; u++) begin : g_ui
        logic signed [SW-1:0] s_lead, s_mid, s_tail;
        logic h_edge, h_mid;
        logic [CODE_W-1:0] c_edge, c_mid;

        assign s_mid  = samples[(2*u)*SW +: SW];
        assign s_tail = samples[(2*u+1)*SW +: SW];
        if (u == 0) begin : g_first
            assign s_lead = prev_q;
        end else begin : g_rest
            assign s_lead = samples[(2*u-1)*SW +: SW];
        end

        cdr_xing_interp #(.SW(SW)) u_edge (
            .x(s_lead), .y(s_mid), .base(CODE_W'(4)),
            .hit(h_edge), .code(c_edge)
        );
        cdr_xing_interp #(.SW(SW)) u_mid (
            .x(s_mid), .y(s_tail), .base(CODE_W'(0)),
            .hit(h_mid), .code(c_mid)
        );

        assign ui_hit[u] = h_edge | h_mid;
        assign ui_code[u*CODE_W +: CODE_W] = h_mid ? c_mid : c_edge;
    end

    cdr_err_accum #(.NUI(NUI), .PH_W(PH_W), .SUM_W(SUM_W)) u_err (
        .hit(ui_hit), .code(ui_code), .avg(phase_avg), .err_sum(err_sum)
    );

    cdr_loop_filter #(.PH_W(PH_W), .SUM_W(SUM_W), .KP_W(KP_W), .KF_W(KF_W)) u_loop (
        .clk(clk), .rst_n(rst_n), .upd(upd), .err_sum(err_sum),
        .kp_shift(kp_shift), .kf_shift(kf_shift), .avg(phase_avg)
    );

    cdr_bit_slicer #(.NS(NS), .SW(SW)) u_slice (
        .samples(samples), .avg_code(phase_avg[PH_W-1 -: CODE_W]), .bits(slice_bits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_out <= '0;
            bits_valid <= 1'b0;
            prev_q <= '0;
        end else begin
            prev_q <= samples[(NS-1)*SW +: SW];
            bits_valid <= upd;
            if (upd) begin
                bits_out <= slice_bits;
            end
        end
    end

endmodule

// File: rtl/cdr_tracker_chk.sv
module cdr_tracker_chk #(
    parameter int NUI   = 8,
    parameter int PH_W  = 10,
    parameter int SUM_W = 13
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic bits_valid,
    input logic [NUI-1:0] bits_out,
    input logic [PH_W-1:0] phase_avg,
    input logic [NUI-1:0] ui_hit,
    input logic signed [SUM_W-1:0] err_sum
);

    // R2
    valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bits_valid |-> $past(en, 2));

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bits_valid |-> $stable(bits_out));

    // R7
    phase_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_avg != $past(phase_avg)) |-> bits_valid);

    // R5
    no_edge_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ui_hit == '0) |-> (err_sum == '0));

endmodule

bind cdr_phase_tracker cdr_tracker_chk #(
    .NUI(NUI), .PH_W(PH_W), .SUM_W(SUM_W)
) u_chk (.*);

// File: tb/sim_cdr_phase_tracker.sv
module sim_cdr_phase_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int NUI = 8;
    localparam int WDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [NS*5-1:0] samples = '0;
    logic [2:0] kp_shift = 3'd2;
    logic [3:0] kf_shift = 4'd6;
    logic [NUI-1:0] bits_out;
    logic bits_valid;
    logic [9:0] phase_avg;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int gidx = 0;
    bit done = 0;

    // reference model state
    int m_avg, m_acc, m_prev;
    bit m_state, m_valid;
    logic [NUI-1:0] m_bits;

    cdr_phase_tracker u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .samples(samples),
        .kp_shift(kp_shift), .kf_shift(kf_shift),
        .bits_out(bits_out), .bits_valid(bits_valid), .phase_avg(phase_avg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sv(int i);
        return int'($signed(samples[i*5 +: 5]));
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic bit crosses(int x, int y);
        return (x < 0) != (y < 0);
    endfunction

    function automatic int interp(int x, int y, int base);
        int s;
        s = iabs(x) + iabs(y);
        return (base + (8 * iabs(x) + s) / (2 * s)) % 8;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_avg = 0; m_acc = 0; m_prev = 0;
            m_state = 0; m_valid = 0; m_bits = '0;
        end else begin
            if (m_state) begin
                int esum;
                int eye;
                int na;
                esum = 0;
                eye = ((m_avg >> 7) + 4) % 8;
                for (int u = 0; u < NUI; u++) begin
                    int lead, mid, tail, code, e;
                    bit hit;
                    lead = (u == 0) ? m_prev : sv(2*u - 1);
                    mid = sv(2*u);
                    tail = sv(2*u + 1);
                    hit = 1; code = 0;
                    if (crosses(mid, tail)) code = interp(mid, tail, 0);
                    else if (crosses(lead, mid)) code = interp(lead, mid, 4);
                    else hit = 0;
                    if (hit) begin
                        e = (code * 128 - m_avg) & 1023;
                        if (e >= 512) e = e - 1024;
                        esum += e;
                    end
                    m_bits[u] = (((eye >= 2) && (eye <= 5)) ? tail : mid) >= 0;
                end
                na = m_acc + (esum >>> kf_shift);
                if (na > 511) na = 511;
                if (na < -512) na = -512;
                m_avg = (m_avg + (esum >>> kp_shift) + m_acc) & 1023;
                m_acc = na;
                m_valid = 1;
            end else begin
                m_valid = 0;
            end
            m_state = en;
            m_prev = sv(NS - 1);
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int dbit(int k);
        return ((k * 40503) >> 4 ^ (k >> 1) ^ (k * 3)) & 1;
    endfunction

    // piecewise-linear data waveform, 8 time steps per UI
    function automatic int wave(int n, int off, int mode);
        int t, k, fr, la, lb, v;
        if (mode == 1) return 9;
        t = 4 * n + off + 60;
        k = t / 8;
        fr = t % 8;
        la = dbit(k) ? 14 : -14;
        lb = dbit(k + 1) ? 14 : -14;
        v = (la * (8 - fr) + lb * fr) / 8;
        if (v > 15) v = 15;
        if (v < -16) v = -16;
        return v;
    endfunction

    task automatic step(int off, int mode);
        @(negedge clk);
        // R3 R4 R5 R6 R7 R9: phase against the model every cycle
        check(phase_avg == 10'(m_avg), "R4 R5 R6 R7 R9 phase_avg", int'(phase_avg), m_avg);
        // R3 R8 R9: recovered word every cycle
        check(bits_out == m_bits, "R3 R8 R9 bits_out", int'(bits_out), int'(m_bits));
        check(bits_valid == m_valid, "R2 bits_valid", int'(bits_valid), int'(m_valid));
        for (int i = 0; i < NS; i++) begin
            int v;
            if (mode == 2) begin
                v = int'($urandom_range(0, 31)) - 16;
                if ($urandom_range(0, 5) == 0) v = 0;
            end else begin
                v = wave(gidx + i, off, mode);
            end
            samples[i*5 +: 5] = 5'(v);
        end
        gidx += NS;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WDOG);
            report();
        end
    end

    initial begin
        int off;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(bits_out == '0, "R1 reset bits_out", int'(bits_out), 0);
        check(bits_valid == 1'b0, "R1 reset bits_valid", int'(bits_valid), 0);
        check(phase_avg == '0, "R1 reset phase_avg", int'(phase_avg), 0);
        rst_n = 1'b1;

        // R2: IDLE holds while data moves past
        for (int c = 0; c < 10; c++) step(3, 0);

        // steady offset, moderate gains
        en = 1'b1;
        for (int c = 0; c < 150; c++) step(3, 0);
        // phase jump
        for (int c = 0; c < 100; c++) step(6, 0);

        // R7: slow drift forces modulo wrap of the average phase
        off = 0;
        for (int c = 0; c < 300; c++) begin
            if (c % 3 == 0) off++;
            step(off % 8, 0);
        end

        // R5: constant data, no crossings
        for (int c = 0; c < 20; c++) step(0, 1);

        // R7: aggressive gains with drift push the frequency term to saturation
        kp_shift = 3'd0; kf_shift = 4'd0;
        for (int c = 0; c < 80; c++) step((c * 5) % 8, 0);
        kp_shift = 3'd3; kf_shift = 4'd9;

        // R4: random samples including zeros, cycle boundary crossings
        for (int c = 0; c < 150; c++) step(0, 2);

        // R2: back to IDLE mid-stream, outputs must hold
        en = 1'b0;
        for (int c = 0; c < 15; c++) step(2, 0);
        en = 1'b1;
        for (int c = 0; c < 40; c++) step(2, 0);

        step(2, 0);
        done = 1;
        report();
    end

endmodule